// File: doc/BRIEF.md
# Load-Use Stall Controller

This block watches a five-stage in-order pipeline for the one data dependency that forwarding cannot cover: an instruction in decode that needs a register which a load, now in execute, has not yet read from memory. When that happens it stops the program counter and the fetch/decode register for one cycle. It also sends a bubble with all-zero controls into the decode/execute register. The consumer is then decoded again one cycle later, and by then the loaded value can be forwarded to it in execute.

So that the bubble can be seen at the ports, the block carries a small model of the program counter, the fetch/decode register and the decode/execute register. The program counter is presented as `pc`. The instruction word at that address comes back on `insn` in the same cycle. The execute-stage contents appear on the `ex_*` outputs, and `ex_pc` identifies which fetched instruction is in execute.

Instruction word (`INSN_W` = 17 with default parameters): bit 16 marks a load, bit 15 marks a register write, bits 14:10 hold the first source (rs), bits 9:5 hold the second source (rt), which is also a load's target, and bits 4:0 hold the destination (rd).

Top module: `lu_stall_ctrl`

## Requirements
- R1: While reset is held and after release until the first edge, `pc` is 0, `ex_valid`, `ex_mem_read` and `ex_reg_write` are 0, `bubble` is 0, and `pc_write` and `ifid_write` are 1.
- R2: A stall (`bubble`=1, `pc_write`=0, `ifid_write`=0) occurs when the instruction in execute is a load (bit 16 set) and its rt (bits 9:5) equals the rs (bits 14:10) of the instruction in decode.
- R3: A stall also occurs when the load's rt equals the rt (bits 9:5) of the instruction in decode.
- R4: An instruction in execute that is not a load never causes a stall, even when its register numbers match those of the decode instruction.
- R5: During a stall cycle `pc` and the fetch/decode register keep their values. `pc_write` and `ifid_write` are both low exactly when `bubble` is high. The held consumer enters execute one cycle later than it would have without the stall.
- R6: In the cycle after a stall, execute holds a bubble: `ex_valid`, `ex_mem_read` and `ex_reg_write` are 0.
- R7: A stall lasts exactly one cycle. `bubble` is never high in two consecutive cycles.
- R8: Without a hazard, every fetched instruction enters execute exactly once, in program order, one cycle after it is fetched. A load followed by an independent instruction and then the consumer produces no bubble.
- R9: A load whose address register is the target of the load just ahead of it stalls once. If that load in turn feeds the next instruction, a second separate stall follows. The execute stream is then load, bubble, load, bubble, consumer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn | input | INSN_W | Instruction word at address `pc` |
| pc | output | PC_W | Program counter (fetch address) |
| pc_write | output | 1 | High when the program counter advances |
| ifid_write | output | 1 | High when the fetch/decode register loads |
| bubble | output | 1 | High when a zero-control bubble is sent into decode/execute |
| ex_valid | output | 1 | Execute stage holds a real instruction |
| ex_pc | output | PC_W | Fetch address of the instruction in execute |
| ex_mem_read | output | 1 | Execute-stage load control |
| ex_reg_write | output | 1 | Execute-stage register-write control |
| ex_rt | output | RW | Execute-stage rt number |
| ex_rd | output | RW | Execute-stage rd number |

## Verification
Two actions coincide in the stall cycle. The program counter and the fetch/decode register are frozen, and the bubble is written into execute. The sharpest case is when the held instruction is itself a load, so the bubble cycle is followed directly by that load's own hazard check. A chain of three instructions (load, dependent load, dependent add) provokes this. The scoreboard expects the exact execute stream: load, bubble, load, bubble, add. In each cycle it also checks that the frozen `pc` matches the value from the previous cycle and that no two bubbles are adjacent.

// File: rtl/lu_stall_ctrl.sv
module lu_stall_ctrl #(
  parameter int RW     = 5,
  parameter int PC_W   = 8,
  parameter int INSN_W = 2 + 3 * RW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INSN_W-1:0] insn,
  output logic [PC_W-1:0]   pc,
  output logic              pc_write,
  output logic              ifid_write,
  output logic              bubble,
  output logic              ex_valid,
  output logic [PC_W-1:0]   ex_pc,
  output logic              ex_mem_read,
  output logic              ex_reg_write,
  output logic [RW-1:0]     ex_rt,
  output logic [RW-1:0]     ex_rd
);
  localparam int LD_B  = INSN_W - 1;
  localparam int WR_B  = INSN_W - 2;
  localparam int RS_LO = 2 * RW;
  localparam int RT_LO = RW;

  logic [PC_W-1:0]   pc_q;
  logic [INSN_W-1:0] id_insn;
  logic [PC_W-1:0]   id_pc;
  logic              id_v;
  logic [RW-1:0]     id_rs, id_rt;
  logic              hazard;

  assign id_rs = id_insn[RS_LO +: RW];
  assign id_rt = id_insn[RT_LO +: RW];

  assign hazard     = ex_mem_read && ((ex_rt == id_rs) || (ex_rt == id_rt));
  assign bubble     = hazard;
  assign pc_write   = !hazard;
  assign ifid_write = !hazard;
  assign pc         = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        pc_q <= '0;
    else if (pc_write) pc_q <= pc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_insn <= '0;
      id_pc   <= '0;
      id_v    <= 1'b0;
    end else if (ifid_write) begin
      id_insn <= insn;
      id_pc   <= pc_q;
      id_v    <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hazard) begin
      ex_valid     <= 1'b0;
      ex_mem_read  <= 1'b0;
      ex_reg_write <= 1'b0;
      ex_pc        <= '0;
      ex_rt        <= '0;
      ex_rd        <= '0;
    end else begin
      ex_valid     <= id_v;
      ex_mem_read  <= id_v && id_insn[LD_B];
      ex_reg_write <= id_v && id_insn[WR_B];
      ex_pc        <= id_pc;
      ex_rt        <= id_rt;
      ex_rd        <= id_insn[0 +: RW];
    end
  end

  // R5
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_write |=> pc == $past(pc));

  // R5
  ifid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ifid_write |=> id_pc == $past(id_pc) && id_insn == $past(id_insn));

  // R6
  bubble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> !ex_valid && !ex_mem_read && !ex_reg_write);

  // R7
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> !bubble);

  // R8
  in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_v && !bubble) |=> ex_valid && ex_pc == $past(id_pc));
endmodule

// File: tb/sim_lu_stall_ctrl.sv
`timescale 1ns/100ps
module sim_lu_stall_ctrl;
  localparam int RW = 5, PC_W = 8, INSN_W = 2 + 3 * RW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [INSN_W-1:0] insn;
  logic [PC_W-1:0] pc, ex_pc;
  logic pc_write, ifid_write, bubble, ex_valid, ex_mem_read, ex_reg_write;
  logic [RW-1:0] ex_rt, ex_rd;

  always #2.5 clk = ~clk;

  lu_stall_ctrl #(.RW(RW), .PC_W(PC_W), .INSN_W(INSN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .insn(insn), .pc(pc), .pc_write(pc_write),
    .ifid_write(ifid_write), .bubble(bubble), .ex_valid(ex_valid), .ex_pc(ex_pc),
    .ex_mem_read(ex_mem_read), .ex_reg_write(ex_reg_write), .ex_rt(ex_rt), .ex_rd(ex_rd));

  logic [INSN_W-1:0] prog [0:15];
  assign insn = prog[pc[3:0]];

  int checks = 0, errors = 0;
  int exp_q[$];
  string req_q[$];
  bit mon_en = 1'b0;
  bit done = 1'b0;
  bit prev_bub = 1'b0;
  logic [PC_W-1:0] prev_pc;

  function automatic logic [INSN_W-1:0] mk(bit ld, bit wr, int rs, int rt, int rd);
    return {ld, wr, rs[RW-1:0], rt[RW-1:0], rd[RW-1:0]};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && exp_q.size() > 0) begin
      int e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk((ex_valid ? int'(ex_pc) : -1) == e, r, "execute entry",
          ex_valid ? int'(ex_pc) : -1, e);
      chk(pc_write == !bubble && ifid_write == !bubble, "R5", "write enables vs bubble",
          {pc_write, ifid_write}, bubble ? 0 : 3);
      if (prev_bub) begin
        chk(pc == prev_pc, "R5", "pc held", pc, prev_pc);
        chk(!ex_mem_read && !ex_reg_write, "R6", "bubble controls",
            {ex_mem_read, ex_reg_write}, 0);
        chk(!bubble, "R7", "second stall cycle", bubble, 0);
      end
      prev_bub = bubble;
      prev_pc  = pc;
    end
  end

  // Driver: reference model at instruction level; pushes the expected execute stream.
  task automatic run(int n, string req);
    int ld_rt;
    bit ld_prev;
    @(negedge clk);
    #1 rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    exp_q.push_back(-1); req_q.push_back("R1");
    ld_prev = 1'b0; ld_rt = 0;
    for (int i = 0; i < n; i++) begin
      int rs, rt;
      rs = int'(prog[i][2*RW +: RW]);
      rt = int'(prog[i][RW +: RW]);
      if (ld_prev && (ld_rt == rs || ld_rt == rt)) begin
        exp_q.push_back(-1); req_q.push_back(req);
      end
      exp_q.push_back(i); req_q.push_back(req);
      ld_prev = prog[i][INSN_W-1];
      ld_rt   = rt;
    end
    #1;
    prev_bub = 1'b0;
    rst_n  = 1'b1;
    mon_en = 1'b1;
    wait (exp_q.size() == 0);
    @(negedge clk);
    #1 mon_en = 1'b0;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = '0;
  endtask

  initial begin
    clear_prog();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pc == 0, "R1", "pc in reset", pc, 0);
    chk(!ex_valid && !ex_mem_read && !ex_reg_write, "R1", "execute empty",
        {ex_valid, ex_mem_read, ex_reg_write}, 0);
    chk(pc_write && ifid_write && !bubble, "R1", "stall outputs idle",
        {pc_write, ifid_write, bubble}, 6);

    // R2: load then dependent add through rs
    clear_prog();
    prog[0] = mk(1, 1, 2, 1, 0);
    prog[1] = mk(0, 1, 1, 4, 3);
    run(6, "R2");

    // R8: independent load placed between
    clear_prog();
    prog[0] = mk(1, 1, 2, 1, 0);
    prog[1] = mk(1, 1, 2, 5, 0);
    prog[2] = mk(0, 1, 1, 4, 3);
    run(6, "R8");

    // R3: dependency through rt
    clear_prog();
    prog[0] = mk(1, 1, 9, 6, 0);
    prog[1] = mk(0, 1, 7, 6, 8);
    run(5, "R3");

    // R4: non-load with matching numbers
    clear_prog();
    prog[0] = mk(0, 1, 2, 1, 1);
    prog[1] = mk(0, 1, 1, 1, 3);
    run(5, "R4");

    // R9: load chain, two separate stalls
    clear_prog();
    prog[0] = mk(1, 1, 3, 1, 0);
    prog[1] = mk(1, 1, 1, 2, 0);
    prog[2] = mk(0, 1, 2, 3, 4);
    run(6, "R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule